// File: doc/BRIEF.md
# Two-Digit 128/64 Quotient Estimator

This unit divides a 128-bit dividend, given as a high word and a low word, by a normalised 64-bit divisor whose top bit is set. It does not produce the exact quotient. It returns a 64-bit estimate that is never below the truncated true quotient and never more than two above it. Normalised floating-point division and square-root datapaths use an estimate like this when a later step corrects the last few units.

The estimate is built as two 32-bit digits. Each digit comes from a narrow 64/32 division by the divisor's upper half. One iterative restoring divider is shared by both digit steps. After the upper digit, the unit forms a 128-bit partial remainder. It repairs that remainder with a short correction loop, and then derives the lower digit from the remainder's middle 64 bits. When the divisor does not exceed the dividend's high word, the quotient cannot fit in 64 bits, so the unit saturates at once.

A request starts with a one-cycle `start_i` while the unit is idle. The result appears on `quot_o` together with a one-cycle `done_o` pulse, and it stays there until the next completion.

Top module: `qest_div128`

## Requirements
- R1: If `div_i <= a_hi_i` when a start is accepted, `quot_o` becomes all ones and `done_o` is high in the cycle right after the start cycle.
- R2: The upper digit is 0xFFFFFFFF when (divisor upper half << 32) is at most the dividend high word. Otherwise it is the high word divided by the divisor upper half. The digit sits in result bits 63:32.
- R3: The partial remainder is the 128-bit dividend minus the 128-bit product of the divisor and the upper digit shifted left by 32. While the remainder's bit 127 is set, the upper digit is decremented by one and (divisor << 32) is added to the remainder modulo 2^128.
- R4: With M as bits 95:32 of the corrected remainder, the lower digit (result bits 31:0) is 0xFFFFFFFF when (divisor upper half << 32) <= M. Otherwise it is M divided by the divisor upper half.
- R5: For a non-saturating request, the result equals the upper digit concatenated with the lower digit. It lies between the truncated quotient q and q+2, inclusive.
- R6: `done_o` is high for exactly one cycle per completed request. `quot_o` holds its value until the next completion.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The running request finishes with its original operands, and no extra completion follows.
- R8: After reset, `busy_o`, `done_o` and `quot_o` are all zero.
- R9: For a non-saturating request, `busy_o` is high from the cycle after the start until the completion cycle, and low once `done_o` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted only while idle |
| a_hi_i | input | 64 | Dividend high word |
| a_lo_i | input | 64 | Dividend low word |
| div_i | input | 64 | Divisor, bit 63 set |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 64 | Quotient estimate |

## Verification
A wrong upper digit, remainder or correction count does not stay hidden inside the unit. It shows on `quot_o` at the next `done_o` pulse, either as a mismatch against the digit rules or as an escape from the [q, q+2] window. This happens roughly 70 cycles after the start. A fault in the shared divider corrupts one of the two 32-bit halves of the result, so the faulty digit step can be told from the half that is wrong. Handshake faults appear within a cycle or two, as a missing or doubled `done_o`, a busy flag that stays high, or a second completion caused by an ignored start.

// File: rtl/qest_pkg.sv
package qest_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HI,
    ST_HI_W,
    ST_MUL,
    ST_FIX,
    ST_LO,
    ST_LO_W
  } qest_st_e;
endpackage

// File: rtl/qest_digit_div.sv
// Restoring divider: 2H-bit numerator / H-bit denominator, numerator high half < denominator.
module qest_digit_div #(
  parameter int H = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           go_i,
  input  logic [2*H-1:0] num_i,
  input  logic [H-1:0]   den_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [H-1:0]   quo_o
);
  localparam int CW = $clog2(H + 1);

  logic [H-1:0]  rem_q, num_q, quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [H:0]    trial, diff;
  logic          ge;

  assign trial = {rem_q, num_q[H-1]};
  assign diff  = trial - {1'b0, den_q};
  assign ge    = trial >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      num_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i && cnt_q == '0) begin
        rem_q <= num_i[2*H-1:H];
        num_q <= num_i[H-1:0];
        den_q <= den_i;
        quo_q <= '0;
        cnt_q <= CW'(H);
      end else if (cnt_q != '0) begin
        rem_q  <= ge ? diff[H-1:0] : trial[H-1:0];
        num_q  <= {num_q[H-2:0], 1'b0};
        quo_q  <= {quo_q[H-2:0], ge};
        cnt_q  <= cnt_q - 1'b1;
        done_q <= (cnt_q == CW'(1));
      end
    end
  end

  assign busy_o = cnt_q != '0;
  assign done_o = done_q;
  assign quo_o  = quo_q;

  // partial remainder stays below the divisor during iteration (digit fits, R4)
  p_rem_below_den_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (rem_q < den_q));
endmodule

// File: rtl/qest_rem_unit.sv
// Partial remainder after the upper digit: dividend - divisor * (zhi << H).
module qest_rem_unit #(
  parameter int W = 64
) (
  input  logic [2*W-1:0] dvd_i,
  input  logic [W-1:0]   div_i,
  input  logic [W/2-1:0] zhi_i,
  output logic [2*W-1:0] rem_o
);
  localparam int H  = W / 2;
  localparam int PW = W + H;

  logic [PW-1:0] prod;

  assign prod  = {{H{1'b0}}, div_i} * {{W{1'b0}}, zhi_i};
  assign rem_o = dvd_i - {prod, {H{1'b0}}};
endmodule

// File: rtl/qest_div128.sv
module qest_div128
  import qest_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] a_hi_i,
  input  logic [W-1:0] a_lo_i,
  input  logic [W-1:0] div_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int H  = W / 2;
  localparam int DW = 2 * W;

  qest_st_e      st_q;
  logic [DW-1:0] dvd_q, rem_q, rem_calc;
  logic [W-1:0]  b_q, quot_q, bhi_sh, rem_mid;
  logic [H-1:0]  zhi_q, dq;
  logic          done_q, hi_sat, lo_sat, div_go, div_busy, div_done;
  logic [W-1:0]  div_num;

  assign bhi_sh  = {b_q[W-1:H], {H{1'b0}}};
  assign rem_mid = rem_q[W+H-1:H];
  assign hi_sat  = bhi_sh <= dvd_q[DW-1:W];
  assign lo_sat  = bhi_sh <= rem_mid;
  assign div_go  = (st_q == ST_HI && !hi_sat) || (st_q == ST_LO && !lo_sat);
  assign div_num = (st_q == ST_LO) ? rem_mid : dvd_q[DW-1:W];

  qest_digit_div #(.H(H)) i_digit_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (div_go),
    .num_i  (div_num),
    .den_i  (b_q[W-1:H]),
    .busy_o (div_busy),
    .done_o (div_done),
    .quo_o  (dq)
  );

  qest_rem_unit #(.W(W)) i_rem_unit (
    .dvd_i (dvd_q),
    .div_i (b_q),
    .zhi_i (zhi_q),
    .rem_o (rem_calc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      dvd_q  <= '0;
      b_q    <= '0;
      zhi_q  <= '0;
      rem_q  <= '0;
      quot_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          dvd_q <= {a_hi_i, a_lo_i};
          b_q   <= div_i;
          if (div_i <= a_hi_i) begin
            quot_q <= '1;
            done_q <= 1'b1;
          end else begin
            st_q <= ST_HI;
          end
        end
        ST_HI: begin
          if (hi_sat) begin
            zhi_q <= '1;
            st_q  <= ST_MUL;
          end else begin
            st_q <= ST_HI_W;
          end
        end
        ST_HI_W: if (div_done) begin
          zhi_q <= dq;
          st_q  <= ST_MUL;
        end
        ST_MUL: begin
          rem_q <= rem_calc;
          st_q  <= ST_FIX;
        end
        ST_FIX: begin
          if (rem_q[DW-1]) begin
            rem_q <= rem_q + {{H{1'b0}}, b_q, {H{1'b0}}};
            zhi_q <= zhi_q - 1'b1;
          end else begin
            st_q <= ST_LO;
          end
        end
        ST_LO: begin
          if (lo_sat) begin
            quot_q <= {zhi_q, {H{1'b1}}};
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            st_q <= ST_LO_W;
          end
        end
        ST_LO_W: if (div_done) begin
          quot_q <= {zhi_q, dq};
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = st_q != ST_IDLE;
  assign done_o = done_q;
  assign quot_o = quot_q;

  p_sat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && div_i <= a_hi_i) |=> (done_o && quot_o == '1));
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_fix_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FIX && rem_q[DW-1]) |=> (zhi_q == $past(zhi_q) - 1'b1));
  p_lo_nonneg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LO) |-> !rem_q[DW-1]);
  p_hold_ops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(b_q) && $stable(dvd_q)));
  p_div_owned_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_busy |-> (st_q == ST_HI_W || st_q == ST_LO_W));
endmodule

// File: tb/test_qest_div128.sv
module test_qest_div128;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] a_hi = '0, a_lo = '0, dv = 64'h8000_0000_0000_0000;
  logic        busy, done;
  logic [63:0] quot;
  int          n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  qest_div128 i_qest_div128 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_hi_i(a_hi), .a_lo_i(a_lo),
    .div_i(dv), .busy_o(busy), .done_o(done), .quot_o(quot)
  );

  function automatic logic [63:0] ref_est(logic [63:0] x0, logic [63:0] x1, logic [63:0] b);
    logic [127:0] rem;
    logic [63:0]  z, bh_sh, mid, bh;
    if (b <= x0) return '1;
    bh    = {32'b0, b[63:32]};
    bh_sh = {b[63:32], 32'b0};
    z = (bh_sh <= x0) ? 64'hFFFF_FFFF_0000_0000 : ((x0 / bh) << 32);
    rem = {x0, x1} - ({64'b0, b} * {64'b0, z});
    for (int k = 0; k < 8 && rem[127]; k++) begin
      z   = z - 64'h1_0000_0000;
      rem = rem + {32'b0, b, 32'b0};
    end
    mid = rem[95:32];
    z = z | ((bh_sh <= mid) ? 64'h0000_0000_FFFF_FFFF : (mid / bh));
    return z;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [63:0] x0, logic [63:0] x1, logic [63:0] b);
    logic [63:0]  exp;
    logic [127:0] q;
    int           cyc;
    while (busy) @(negedge clk);
    a_hi = x0; a_lo = x1; dv = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    exp = ref_est(x0, x1, b);
    if (b <= x0) begin
      check(done === 1'b1, "R1 done latency", {63'b0, done}, 64'd1);
      check(quot === '1, "R1 saturate", quot, '1);
    end else begin
      check(busy === 1'b1 && done === 1'b0, "R9 busy after start", {62'b0, busy, done}, 64'd2);
      cyc = 0;
      while (!done && cyc < 400) begin @(negedge clk); cyc++; end
      check(quot === exp, "R2 R3 R4 R5 digits", quot, exp);
      q = {x0, x1} / {64'b0, b};
      check(({64'b0, quot} >= q) && ({64'b0, quot} <= q + 2), "R5 window", quot, q[63:0]);
      check(busy === 1'b0, "R9 idle at done", {63'b0, busy}, 64'd0);
    end
    @(negedge clk);
    check(done === 1'b0 && quot === exp, "R6 pulse/hold", {63'b0, done}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] r0, r1, rb, keep;
    int          cyc;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    check(busy === 0 && done === 0 && quot === 0, "R8 reset", quot, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run(64'h7FFF_FFFF_FFFF_FFFF, '1, 64'h8000_0000_0000_0000);
    run(64'h0, 64'h1234_5678_9ABC_DEF0, '1);
    run(64'h8000_0000_0000_0001, 64'h0, 64'h8000_0000_FFFF_FFFF);
    run(64'h8000_0000_7FFF_FFFF, '1, 64'h8000_0000_FFFF_FFFF);
    run(64'hFFFF_FFFF_0000_0000, 64'h0, 64'hFFFF_FFFF_0000_0001);
    run(64'h9000_0000_0000_0000, 64'h5, 64'h9000_0000_0000_0000); // R1 equal
    run('1, '1, 64'h8000_0000_0000_0000); // R1 above
    run(64'hFFFF_FFFE_FFFF_FFFF, '1, 64'hFFFF_FFFF_0000_0000);
    // random
    for (int i = 0; i < 300; i++) begin
      rb = {$urandom, $urandom} | 64'h8000_0000_0000_0000;
      r1 = {$urandom, $urandom};
      r0 = {$urandom, $urandom};
      if (i % 4 == 1) r0 = {rb[63:32], $urandom};
      if (i % 10 != 3 && r0 >= rb) r0 = r0 - rb;
      if (i % 10 != 3 && r0 >= rb) r0 = rb - 1;
      run(r0, r1, rb);
    end
    // R7: start while busy is ignored
    while (busy) @(negedge clk);
    a_hi = 64'h1234_5678_0000_0000; a_lo = 64'hCAFE; dv = 64'hC000_0000_1234_5678; start = 1'b1;
    keep = ref_est(64'h1234_5678_0000_0000, 64'hCAFE, 64'hC000_0000_1234_5678);
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    a_hi = 64'h1; a_lo = 64'h2; dv = 64'h8000_0000_0000_0003; start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 400) begin @(negedge clk); cyc++; end
    check(quot === keep, "R7 original operands", quot, keep);
    cyc = 0;
    for (int k = 0; k < 120; k++) begin @(negedge clk); if (done) cyc++; end
    check(cyc == 0 && busy === 0, "R7 no extra done", 64'(cyc), 64'd0);
    check(quot === keep, "R6 hold after idle", quot, keep);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule